// File: doc/BRIEF.md
# Word-Portion Operand Selector and Merger

This block sits between a 24-bit memory data word and a 24-bit arithmetic register. A 3-bit portion code selects which part of the word an instruction works on. The choices are the whole word, one of the three 8-bit thirds, or the low 15-bit field.

On the load side, the block takes the selected portion of the memory word and moves it to the low end of a 24-bit operand. It fills the upper bits either with copies of the byte's top bit or with zeros. On the store side, it performs the merge step of a read-modify-write. The low bits of the register value are written into the selected portion of the old memory word, and every other bit of that word is left as it was. When an opcode does not use portions, the enable input is held low and both paths pass full words.

Both results are registered once by default. A parameter removes that register, which makes the block purely combinational.

Top module: `portion_path`

## Requirements
- R1: With the enable high and code 0, the operand equals the memory word and the merged word equals the register value.
- R2: With the enable high and code 1, 2 or 3, the block selects memory bits 7..0, 15..8 or 23..16 respectively. The selected byte is placed in operand bits 7..0, and operand bits 23..8 all copy bit 7 of that byte.
- R3: With the enable high and code 5, 6 or 7, the same thirds as in R2 are selected and placed in operand bits 7..0, and operand bits 23..8 are zero.
- R4: With the enable high and code 4, operand bits 14..0 equal memory bits 14..0 and operand bits 23..15 are zero.
- R5: With the enable high and any byte code (1, 2, 3, 5, 6, 7), the merged word carries register bits 7..0 in the third selected as in R2. Its other 16 bits equal the memory word.
- R6: With the enable high and code 4, merged bits 14..0 equal register bits 14..0 and merged bits 23..15 equal memory bits 23..15.
- R7: With the enable low, the operand equals the memory word and the merged word equals the register value, for every code.
- R8: In the default registered form, both outputs reflect the inputs sampled at the previous rising clock edge. While the active-low reset is asserted, both outputs read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| mem_word_in | input | 24 | Word read from memory |
| reg_in | input | 24 | Arithmetic register value to be stored |
| code | input | 3 | Portion code |
| portion_en | input | 1 | High when the opcode uses the portion code |
| operand_out | output | 24 | Right-aligned, extended operand for the load path |
| merged_word_out | output | 24 | Memory word with the selected portion replaced, for the store path |

## Verification
Both results are due exactly one rising edge after their inputs were presented, because each passes through a single output register. The bench drives new inputs on the falling edge and pushes the expected pair into a queue at the same moment. On the next falling edge it pops that pair and compares it with the outputs. Each comparison therefore sees the register that was loaded by the edge in between, and never a value that is still changing. During reset the bench expects zeros and does not use the queue.

// File: rtl/portion_path.sv
module portion_path #(
  parameter int WORD_W  = 24,
  parameter int BYTE_W  = 8,
  parameter int FIELD_W = 15,
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] mem_word_in,
  input  logic [WORD_W-1:0] reg_in,
  input  logic [2:0]        code,
  input  logic              portion_en,
  output logic [WORD_W-1:0] operand_out,
  output logic [WORD_W-1:0] merged_word_out
);
  localparam int LANES = WORD_W / BYTE_W;
  localparam int UP_W  = WORD_W - BYTE_W;
  localparam int HI_W  = WORD_W - FIELD_W;

  logic [1:0]        lane_sel;
  logic              is_byte, is_field, fill;
  logic [BYTE_W-1:0] picked;
  logic [WORD_W-1:0] ld_next, st_next;

  assign lane_sel = code[1:0] - 2'd1;
  assign is_byte  = portion_en && (code[1:0] != 2'd0);
  assign is_field = portion_en && (code == 3'd4);

  always_comb begin
    picked = '0;
    for (int i = 0; i < LANES; i++)
      if (lane_sel == i[1:0]) picked = mem_word_in[i*BYTE_W +: BYTE_W];
  end

  assign fill = ~code[2] & picked[BYTE_W-1];

  assign ld_next = is_byte  ? {{UP_W{fill}}, picked} :
                   is_field ? {{HI_W{1'b0}}, mem_word_in[FIELD_W-1:0]} :
                              mem_word_in;

  always_comb begin
    if (is_field) begin
      st_next = {mem_word_in[WORD_W-1:FIELD_W], reg_in[FIELD_W-1:0]};
    end else if (is_byte) begin
      st_next = mem_word_in;
      for (int i = 0; i < LANES; i++)
        if (lane_sel == i[1:0]) st_next[i*BYTE_W +: BYTE_W] = reg_in[BYTE_W-1:0];
    end else begin
      st_next = reg_in;
    end
  end

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          operand_out     <= '0;
          merged_word_out <= '0;
        end else begin
          operand_out     <= ld_next;
          merged_word_out <= st_next;
        end
      end
    end else begin : g_comb
      assign operand_out     = ld_next;
      assign merged_word_out = st_next;
    end
  endgenerate
endmodule

// File: rtl/portion_path_chk.sv
module portion_path_chk #(
  parameter int WORD_W  = 24,
  parameter int BYTE_W  = 8,
  parameter int FIELD_W = 15,
  parameter bit REG_OUT = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [WORD_W-1:0] mem_word_in,
  input logic [WORD_W-1:0] reg_in,
  input logic [2:0]        code,
  input logic              portion_en,
  input logic [WORD_W-1:0] operand_out,
  input logic [WORD_W-1:0] merged_word_out
);
  logic [WORD_W-1:0] d_mem, d_reg, e_mem, e_reg;
  logic [2:0]        d_code, e_code;
  logic              d_en, e_en, ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_mem <= '0; d_reg <= '0; d_code <= '0; d_en <= 1'b0; ok <= 1'b0;
    end else begin
      d_mem <= mem_word_in; d_reg <= reg_in; d_code <= code; d_en <= portion_en;
      ok <= 1'b1;
    end
  end

  assign e_mem  = REG_OUT ? d_mem  : mem_word_in;
  assign e_reg  = REG_OUT ? d_reg  : reg_in;
  assign e_code = REG_OUT ? d_code : code;
  assign e_en   = REG_OUT ? d_en   : portion_en;

  AST_FULL_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (ok && e_en && e_code == 3'd0) |-> (operand_out == e_mem && merged_word_out == e_reg)); // R1
  AST_SIGN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (ok && e_en && e_code inside {3'd1, 3'd2, 3'd3}) |->
      (operand_out[WORD_W-1:BYTE_W] == {(WORD_W-BYTE_W){operand_out[BYTE_W-1]}})); // R2
  AST_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (ok && e_en && e_code inside {3'd5, 3'd6, 3'd7}) |->
      (operand_out[WORD_W-1:BYTE_W] == '0)); // R3
  AST_FIELD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (ok && e_en && e_code == 3'd4) |->
      (operand_out == {{(WORD_W-FIELD_W){1'b0}}, e_mem[FIELD_W-1:0]})); // R4
  AST_LOW_THIRD_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
    (ok && e_en && e_code[1:0] == 2'd1) |->
      (merged_word_out[BYTE_W-1:0] == e_reg[BYTE_W-1:0] &&
       merged_word_out[WORD_W-1:BYTE_W] == e_mem[WORD_W-1:BYTE_W])); // R5
  AST_FIELD_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
    (ok && e_en && e_code == 3'd4) |->
      (merged_word_out == {e_mem[WORD_W-1:FIELD_W], e_reg[FIELD_W-1:0]})); // R6
  AST_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    (ok && !e_en) |-> (operand_out == e_mem && merged_word_out == e_reg)); // R7

  generate
    if (REG_OUT) begin : g_rst
      AST_RESET_ZERO: assert property (@(posedge clk)
        !rst_n |-> (operand_out == '0 && merged_word_out == '0)); // R8
    end
  endgenerate
endmodule

bind portion_path portion_path_chk #(
  .WORD_W(WORD_W), .BYTE_W(BYTE_W), .FIELD_W(FIELD_W), .REG_OUT(REG_OUT)
) u_chk (.*);

// File: tb/portion_path_bench.sv
`timescale 1ns/1ps
module portion_path_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] mem_word_in = '0, reg_in = '0;
  logic [2:0]  code = '0;
  logic        portion_en = 1'b0;
  logic [23:0] operand_out, merged_word_out;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [23:0] q_ld[$], q_st[$];
  string q_tl[$], q_ts[$];

  always #2 clk = ~clk;

  portion_path u_portion_path (.*);

  function automatic logic [23:0] ref_load(logic [23:0] m, logic [2:0] c, logic en);
    int sh;
    logic [23:0] v;
    if (!en || c == 0) return m;
    if (c == 4) return m & 24'h007FFF;
    sh = (int'(c) % 4 - 1) * 8;
    v = (m >> sh) & 24'h0000FF;
    if (c < 4 && v[7]) v = v | 24'hFFFF00;
    return v;
  endfunction

  function automatic logic [23:0] ref_store(logic [23:0] m, logic [23:0] r, logic [2:0] c, logic en);
    int sh;
    logic [23:0] mask;
    if (!en || c == 0) return r;
    if (c == 4) return (m & 24'hFF8000) | (r & 24'h007FFF);
    sh = (int'(c) % 4 - 1) * 8;
    mask = 24'h0000FF << sh;
    return (m & ~mask) | ((r & 24'h0000FF) << sh);
  endfunction

  function automatic string tag_ld(logic [2:0] c, logic en);
    if (!en) return "R7";
    if (c == 0) return "R1";
    if (c == 4) return "R4";
    return (c < 4) ? "R2" : "R3";
  endfunction

  function automatic string tag_st(logic [2:0] c, logic en);
    if (!en) return "R7";
    if (c == 0) return "R1";
    if (c == 4) return "R6";
    return "R5";
  endfunction

  task automatic cmp(string tag, string what, logic [23:0] act, logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %06h expected %06h", tag, what, act, exp);
    end
  endtask

  // At each falling edge: compare the outputs due now, then present the next inputs
  task automatic step(logic [23:0] m, logic [23:0] r, logic [2:0] c, logic en);
    @(negedge clk);
    if (q_ld.size() > 0)
      begin
        cmp(q_tl.pop_front(), "operand", operand_out, q_ld.pop_front());
        cmp(q_ts.pop_front(), "merged", merged_word_out, q_st.pop_front());
      end
    mem_word_in = m; reg_in = r; code = c; portion_en = en;
    q_ld.push_back(ref_load(m, c, en));
    q_st.push_back(ref_store(m, r, c, en));
    q_tl.push_back(tag_ld(c, en));
    q_ts.push_back(tag_st(c, en));
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    mem_word_in = 24'hA5C3F1; reg_in = 24'h123456; code = 3'd2; portion_en = 1'b1;
    repeat (3) @(negedge clk);
    cmp("R8", "operand in reset", operand_out, 24'h0);
    cmp("R8", "merged in reset", merged_word_out, 24'h0);
    rst_n = 1'b1;
    // Directed: every code, with the top bit of each byte set and then clear
    for (int c = 0; c < 8; c++) begin
      step(24'h9C83F7, 24'h5A6B7C, 3'(c), 1'b1);
      step(24'h4C3A71, 24'hF1E2D3, 3'(c), 1'b1);
      step(24'hFFFFFF, 24'h000000, 3'(c), 1'b1);
      step(24'h000000, 24'hFFFFFF, 3'(c), 1'b1);
    end
    // Bypass with each code (R7)
    for (int c = 0; c < 8; c++) step(24'h8080FF ^ 24'(c), 24'h7F00AA, 3'(c), 1'b0);
    // Back-to-back changing patterns check the one-cycle latency (R8)
    for (int n = 0; n < 400; n++)
      step(24'($urandom), 24'($urandom), 3'($urandom), 1'($urandom % 4 != 0));
    step(24'h0, 24'h0, 3'd0, 1'b1);
    @(negedge clk);
    cmp("R8", "final operand", operand_out, 24'h0);
    cmp("R8", "final merged", merged_word_out, 24'h0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule